// File: doc/BRIEF.md
# Interrupt Target Routing Registers

This block holds the per-interrupt processor target masks of an interrupt distributor. Every interrupt owns one byte. Bit n of that byte means processor n may receive the interrupt. Software reaches the masks through a simple register port that takes both full-word and single-byte accesses. Four interrupts share one 32-bit word, and byte lane k of word w belongs to interrupt 4·w + k.

Each shared interrupt's mask is reduced to one routed processor ID. That ID is the position of the lowest set bit, or 0 when the mask is empty. It is presented on a flat output bus that the delivery logic can pick from. The low interrupts are private to each processor. Their entries cannot be written, and a read of one returns a one-hot byte that names the processor doing the read. Any address past the configured interrupt count reads as zero and drops writes.

Top module: `irq_route_regs`

## Requirements
- R1: After reset, every shared mask reads as zero, every routed ID is zero and `rd_valid` is low.
- R2: A word write (`acc_byte`=0) stores `acc_wdata[8k+7:8k]` into the interrupt at 4·(`acc_addr`>>2)+k, for k = 0..3. `acc_addr[1:0]` is ignored in word mode.
- R3: A byte write (`acc_byte`=1) stores `acc_wdata[7:0]` into the interrupt at (`acc_addr`>>2)·4 + `acc_addr[1:0]` only. The other three entries of that word keep their values.
- R4: Writes to interrupts below `PRIV_IRQ` (default 32) change nothing.
- R5: A read of a private word returns the byte (1 << `acc_cpu`) in every lane.
- R6: The routed ID of a shared interrupt is the index of the lowest set bit of its mask. It shows on `route_o[3i+2:3i]` from the clock edge that accepts the write.
- R7: A shared interrupt whose mask is zero routes to processor 0.
- R8: A word read returns the four masks packed with the lowest interrupt in bits 7:0. It appears on `rd_data` with `rd_valid`=1 one cycle after the request, and `rd_valid` is 0 after any cycle without a read.
- R9: A byte read returns the selected lane's mask in `rd_data[7:0]`, with bits 31:8 zero.
- R10: An access whose interrupt index is `NUM_IRQ` or higher reads as zero and leaves all state and routed IDs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Access request this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_byte | input | 1 | 1 = 8-bit access, 0 = 32-bit access |
| acc_addr | input | ADDR_W | Byte address; bits above 1 select the word |
| acc_wdata | input | 32 | Write data |
| acc_cpu | input | 3 | ID of the processor making the access |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Registered read data |
| route_o | output | 3*NUM_IRQ | Routed processor ID, 3 bits per interrupt |

## Verification
The hardest case to reach from the ports is a shared entry that keeps its old mask while a neighbour in the same word is rewritten by a byte access. The failure is silent unless the untouched lane is read back later and its routed ID is compared. The stimulus interleaves random byte and word writes across shared, private and out-of-range words with full reads. After every write the bench compares all routed IDs against a byte-level model, so a stray lane enable shows up as a wrong ID on an interrupt that was never addressed.

// File: rtl/irq_route_pkg.sv
// Shared types and helpers for the target routing register file.
// Assumes 8 processors at most, so one mask byte and a 3-bit ID.
package irq_route_pkg;
    localparam int MASK_W = 8;
    localparam int RID_W  = 3;

    typedef logic [MASK_W-1:0] tmask_t;
    typedef logic [RID_W-1:0]  rid_t;

    // Decoded view of one access
    typedef struct packed {
        logic       in_range;
        logic       priv;
        logic [3:0] lane_en;
    } acc_dec_t;

    // Index of the lowest set bit; zero for an empty mask
    function automatic rid_t lowest_bit(input tmask_t m);
        rid_t r;
        r = '0;
        for (int i = MASK_W - 1; i >= 0; i--) begin
            if (m[i]) r = rid_t'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_route_decode.sv
// Address decoder: splits the byte address into a word index and lane
// enables, and classifies the word as private, shared or out of range.
// Assumes NUM_IRQ and PRIV_IRQ are multiples of four.
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int NUM_IRQ  = 64,
    parameter int PRIV_IRQ = 32,
    parameter int ADDR_W   = 7,
    localparam int WIDX_W  = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              byte_mode,
    output logic [WIDX_W-1:0] word_idx,
    output logic [1:0]        lane,
    output acc_dec_t          dec
);
    logic [ADDR_W-1:0] base_irq;

    // Classify the word addressed and build the lane enables
    always_comb begin
        word_idx     = addr[ADDR_W-1:2];
        lane         = addr[1:0];
        base_irq     = {addr[ADDR_W-1:2], 2'b00};
        dec.in_range = (int'(base_irq) < NUM_IRQ);
        dec.priv     = (int'(base_irq) < PRIV_IRQ);
        dec.lane_en  = byte_mode ? (4'b0001 << addr[1:0]) : 4'b1111;
    end
endmodule

// File: rtl/irq_route_entry.sv
// One shared interrupt: its target mask and the routed processor ID
// derived from it. Both registers load together on a write.
module irq_route_entry
    import irq_route_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  tmask_t wr_mask,
    output tmask_t mask_o,
    output rid_t   route_o
);
    tmask_t mask_q;
    rid_t   route_q;

    // Store the mask and its lowest-bit processor ID
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            route_q <= '0;
        end else if (wr_en) begin
            mask_q  <= wr_mask;
            route_q <= lowest_bit(wr_mask);
        end
    end

    assign mask_o  = mask_q;
    assign route_o = route_q;

    // R6
    route_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q != '0) |-> (mask_q[route_q] &&
            ((mask_q & ((tmask_t'(1) << route_q) - tmask_t'(1))) == '0)));
    // R7
    route_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> (route_q == '0));
    // R3
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q));
endmodule

// File: rtl/irq_route_rdmux.sv
// Read multiplexer: selects the addressed word from the flattened mask
// array, then narrows it to one lane for byte reads. Out-of-range words
// read as zero. Private bytes are assumed already filled by the caller.
module irq_route_rdmux #(
    parameter int NUM_IRQ = 64,
    parameter int WIDX_W  = 5,
    localparam int NUM_WORDS = NUM_IRQ / 4
) (
    input  logic [NUM_IRQ*8-1:0] masks,
    input  logic [WIDX_W-1:0]    word_idx,
    input  logic [1:0]           lane,
    input  logic                 in_range,
    input  logic                 byte_mode,
    output logic [31:0]          rdata
);
    logic [31:0] word_sel;

    // Pick the addressed word, zero outside the configured range
    always_comb begin
        word_sel = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (in_range && (word_idx == WIDX_W'(w))) word_sel = masks[w*32 +: 32];
        end
    end

    // Narrow to the addressed lane for byte reads
    always_comb begin
        if (byte_mode) rdata = {24'h0, word_sel[8*lane +: 8]};
        else           rdata = word_sel;
    end
endmodule

// File: rtl/irq_route_regs.sv
// Target routing register file. Holds one mask byte per shared interrupt,
// answers private reads with the accessing processor's one-hot byte, and
// drives a routed processor ID per interrupt. Read data is registered.
// Assumes NUM_IRQ and PRIV_IRQ are multiples of four, PRIV_IRQ <= NUM_IRQ.
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int NUM_IRQ  = 64,
    parameter int PRIV_IRQ = 32,
    parameter int ADDR_W   = $clog2(NUM_IRQ) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_en,
    input  logic                   acc_wr,
    input  logic                   acc_byte,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic [31:0]            acc_wdata,
    input  logic [2:0]             acc_cpu,
    output logic                   rd_valid,
    output logic [31:0]            rd_data,
    output logic [NUM_IRQ*3-1:0]   route_o
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0]    word_idx;
    logic [1:0]           lane;
    acc_dec_t             dec;
    logic [NUM_IRQ*8-1:0] masks;
    logic [31:0]          rdata_c;
    logic                 wr_go;
    tmask_t               cpu_onehot;

    irq_route_decode #(
        .NUM_IRQ (NUM_IRQ),
        .PRIV_IRQ(PRIV_IRQ),
        .ADDR_W  (ADDR_W)
    ) decode_i (
        .addr     (acc_addr),
        .byte_mode(acc_byte),
        .word_idx (word_idx),
        .lane     (lane),
        .dec      (dec)
    );

    // Writes that may land: in range and not private
    assign wr_go      = acc_en && acc_wr && dec.in_range && !dec.priv;
    assign cpu_onehot = tmask_t'(1) << acc_cpu;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_IRQ; gi++) begin : g_irq
            if (gi < PRIV_IRQ) begin : g_priv
                // Private entry: read-only, mirrors the accessor's own bit
                assign masks[gi*8 +: 8]   = cpu_onehot;
                assign route_o[gi*3 +: 3] = '0;
            end else begin : g_shared
                logic   wr_en;
                tmask_t wr_mask;
                // Lane select and data steering for this entry
                assign wr_en   = wr_go && (word_idx == WIDX_W'(gi / 4))
                                 && dec.lane_en[gi % 4];
                assign wr_mask = acc_byte ? acc_wdata[7:0]
                                          : acc_wdata[(gi % 4)*8 +: 8];
                irq_route_entry entry_i (
                    .clk    (clk),
                    .rst_n  (rst_n),
                    .wr_en  (wr_en),
                    .wr_mask(wr_mask),
                    .mask_o (masks[gi*8 +: 8]),
                    .route_o(route_o[gi*3 +: 3])
                );
            end
        end
    endgenerate

    irq_route_rdmux #(
        .NUM_IRQ(NUM_IRQ),
        .WIDX_W (WIDX_W)
    ) rdmux_i (
        .masks    (masks),
        .word_idx (word_idx),
        .lane     (lane),
        .in_range (dec.in_range),
        .byte_mode(acc_byte),
        .rdata    (rdata_c)
    );

    // Register the read result and its valid strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= acc_en && !acc_wr;
            if (acc_en && !acc_wr) rd_data <= rdata_c;
        end
    end

    // R8
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr) |=> rd_valid);
    // R8
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && !acc_wr) |=> !rd_valid);
    // R10
    oor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && !dec.in_range) |=> (rd_data == '0));
    // R9
    byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && acc_byte) |=> (rd_data[31:8] == '0));
    // R5
    priv_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && !acc_byte && dec.priv)
        |=> ($countones(rd_data) == 4));
endmodule

// File: tb/irq_route_regs_tb_top.sv
`timescale 1ns/1ps
module irq_route_regs_tb_top;
    localparam int NUM_IRQ  = 64;
    localparam int PRIV_IRQ = 32;
    localparam int ADDR_W   = $clog2(NUM_IRQ) + 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 acc_en = 1'b0;
    logic                 acc_wr = 1'b0;
    logic                 acc_byte = 1'b0;
    logic [ADDR_W-1:0]    acc_addr = '0;
    logic [31:0]          acc_wdata = '0;
    logic [2:0]           acc_cpu = '0;
    logic                 rd_valid;
    logic [31:0]          rd_data;
    logic [NUM_IRQ*3-1:0] route_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] model [NUM_IRQ];

    always #2.5 clk = ~clk;

    irq_route_regs #(.NUM_IRQ(NUM_IRQ), .PRIV_IRQ(PRIV_IRQ)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_byte(acc_byte), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_cpu(acc_cpu), .rd_valid(rd_valid), .rd_data(rd_data),
        .route_o(route_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] ref_route(input int irq);
        logic [2:0] r = 3'd0;
        bit found = 0;
        if (irq < PRIV_IRQ) return 3'd0;
        for (int b = 0; b < 8; b++) begin
            if (!found && model[irq][b]) begin
                r = 3'(b);
                found = 1;
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] ref_read(input int addr, input bit bm, input logic [2:0] cpu);
        int base = addr & ~3;
        logic [31:0] w = '0;
        if (base >= NUM_IRQ) return '0;
        for (int k = 0; k < 4; k++)
            w[8*k +: 8] = (base < PRIV_IRQ) ? (8'd1 << cpu) : model[base + k];
        if (bm) return {24'h0, w[8*(addr & 3) +: 8]};
        return w;
    endfunction

    task automatic ref_write(input int addr, input bit bm, input logic [31:0] d);
        int base = addr & ~3;
        if (base >= NUM_IRQ || base < PRIV_IRQ) return;
        if (bm) model[base + (addr & 3)] = d[7:0];
        else for (int k = 0; k < 4; k++) model[base + k] = d[8*k +: 8];
    endtask

    task automatic check_routes(input string req);
        for (int i = 0; i < NUM_IRQ; i++)
            check(req, {29'h0, route_o[i*3 +: 3]}, {29'h0, ref_route(i)});
    endtask

    task automatic do_write(input int addr, input bit bm, input logic [31:0] d, input string req);
        @(negedge clk);
        acc_en = 1; acc_wr = 1; acc_byte = bm;
        acc_addr = ADDR_W'(addr); acc_wdata = d;
        @(negedge clk);
        acc_en = 0; acc_wr = 0;
        ref_write(addr, bm, d);
        check({req, " rd_valid after write"}, {31'h0, rd_valid}, 32'h0);
        check_routes(req);
    endtask

    task automatic do_read(input int addr, input bit bm, input logic [2:0] cpu, input string req);
        @(negedge clk);
        acc_en = 1; acc_wr = 0; acc_byte = bm;
        acc_addr = ADDR_W'(addr); acc_cpu = cpu;
        @(negedge clk);
        acc_en = 0;
        check({req, " rd_valid"}, {31'h0, rd_valid}, 32'h1);
        check(req, rd_data, ref_read(addr, bm, cpu));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        process::self().srandom(32'h5eed_0042);
        for (int i = 0; i < NUM_IRQ; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1 rd_valid", {31'h0, rd_valid}, 32'h0);
        check_routes("R1 routes");
        do_read(PRIV_IRQ, 0, 3'd0, "R1 shared word");
        do_read(NUM_IRQ - 4, 0, 3'd0, "R1 last word");

        // R2 R6 R7 R8: word write and packing
        do_write(32, 0, 32'h8004_00F0, "R2 R6 R7 word write");
        check("R6 irq32", {29'h0, route_o[32*3 +: 3]}, 32'd4);
        check("R7 irq33", {29'h0, route_o[33*3 +: 3]}, 32'd0);
        check("R6 irq35", {29'h0, route_o[35*3 +: 3]}, 32'd7);
        do_read(32, 0, 3'd0, "R8 word read");
        check("R8 packing", rd_data, 32'h8004_00F0);

        // R2: misaligned word address ignores low bits
        do_write(47, 0, 32'h0102_0408, "R2 misaligned word");
        do_read(44, 0, 3'd0, "R2 readback");

        // R3 R9: byte write touches one lane
        do_write(41, 1, 32'hFFFF_FFAC, "R3 byte write");
        do_read(40, 0, 3'd0, "R3 neighbours kept");
        do_read(41, 1, 3'd0, "R9 byte read");
        check("R9 byte value", rd_data, 32'h0000_00AC);

        // R4 R5: private entries
        do_write(0, 0, 32'hFFFF_FFFF, "R4 private word write");
        do_write(PRIV_IRQ - 1, 1, 32'h0000_0040, "R4 private byte write");
        do_read(0, 0, 3'd5, "R5 private read cpu5");
        check("R5 onehot", rd_data, 32'h2020_2020);
        do_read(PRIV_IRQ - 2, 1, 3'd7, "R5 private byte cpu7");

        // R10: out of range
        do_write(NUM_IRQ, 0, 32'h1111_1111, "R10 oor write");
        do_write(NUM_IRQ + 5, 1, 32'h0000_0022, "R10 oor byte write");
        do_read(NUM_IRQ + 8, 0, 3'd1, "R10 oor read");
        check("R10 zero", rd_data, 32'h0);

        // R7: clearing back to empty
        do_write(35, 1, 32'h0, "R7 clear irq35");

        // Random mix across all regions (R2 R3 R4 R8 R9 R10)
        for (int n = 0; n < 400; n++) begin
            int a = int'($urandom_range(0, 2 * NUM_IRQ - 1));
            bit bm = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 1) == 1)
                do_write(a, bm, $urandom, "R2 R3 R4 R10 random write");
            else
                do_read(a, bm, 3'($urandom_range(0, 7)), "R8 R9 R5 random read");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule